// File: doc/BRIEF.md
# Page Write Buffer and Commit Engine

This block gathers data bytes that a bus sequencer delivers one bit at a time, holds them in a 32-byte page buffer, and then copies them into a register-array model of a 2K x 8 nonvolatile memory. The sequencer first gives a start address. That address selects the page, through its upper bits, and the first byte slot, through its low five bits. The sequencer then streams data bits most significant bit first and signals the end of the load. It finally asks for a commit. Loading past the last slot of the page wraps back to slot 0 of the same page, so later bytes overwrite earlier ones.

A commit starts only when three conditions hold: the write-enable latch is set, the load has ended, and the load holds at least one byte and no partial byte. While the commit runs, the ready status output is low. It stays low for a parameterised number of cycles that stands in for the programming time. During that time the block writes, one byte per cycle, every slot that was loaded. It drops any byte whose address an external protection checker refuses. A refused commit clears the write-enable latch, and so does a finished one. A new reset sequence (`arm_i`) sets the latch again.

The bit input is a valid/ready stream. A bit is taken in any cycle where `bit_valid_i` and `bit_ready_o` are both high. `bit_ready_o` is high only while a load is open and no commit is running. The sender must hold `bit_data_i` until the bit is taken; a sender that does not wait for ready loses the bit. All other pins are plain single-cycle controls.

Top module: `pwb_top`

## Requirements
- R1: `start_i` opens a load. Bits taken from the stream are gathered most significant bit first, and every 8 bits form one byte. That byte goes to the slot given by the start address's low 5 bits, and following bytes go to the slots after it.
- R2: After slot 31, the slot pointer wraps to slot 0 of the same page. The 33rd byte of a load overwrites the 1st.
- R3: A commit request that is accepted drives `ready_o` low from the next cycle, for exactly PROG_CYCLES cycles. It is accepted only when the latch is set, the load has ended, at least one byte was loaded, and no byte is partial.
- R4: A commit writes only the slots that were loaded. Every other address of the array keeps its old contents.
- R5: A loaded byte is not written when `prot_ok_i` is low for its address. The other loaded bytes of the page are still written.
- R6: A commit request is refused when a byte is partial (bit count not a multiple of 8). `ready_o` stays high, and the latch is cleared, so a later complete load also fails until `arm_i` is given again.
- R7: A commit request is refused when the write-enable latch is clear, or when the load has not been ended.
- R8: The latch clears when a commit finishes. A second load committed without a new `arm_i` is refused.
- R9: While busy, `start_i`, `arm_i`, `commit_i`, `abort_i`, `load_end_i` and stream bits are ignored.
- R10: `abort_i` closes the load and discards its bytes. A commit after it is refused.
- R11: `bit_ready_o` is high only between `start_i` and the end of the load (`load_end_i`, `abort_i`, or a refused commit), and only while not busy.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| arm_i | input | 1 | Reset sequence seen; sets the write-enable latch |
| start_i | input | 1 | Open a load at `start_addr_i` |
| start_addr_i | input | AW | Start byte address |
| bit_valid_i | input | 1 | Stream bit valid |
| bit_data_i | input | 1 | Stream bit value |
| bit_ready_o | output | 1 | Stream bit accepted this cycle if valid |
| load_end_i | input | 1 | Close the load |
| abort_i | input | 1 | Close the load and discard it |
| commit_i | input | 1 | Request a commit |
| prot_addr_o | output | AW | Address being committed, sent to the protection checker |
| prot_ok_i | input | 1 | Checker permits writing `prot_addr_o` |
| mem_we_o | output | 1 | Array write strobe |
| mem_addr_o | output | AW | Array write address |
| mem_data_o | output | 8 | Array write data |
| rd_addr_i | input | AW | Array read address |
| rd_data_o | output | 8 | Array read data (combinational) |
| ready_o | output | 1 | Status: 0 while committing, 1 otherwise |

## Verification
A bit or control pulse driven before a clock edge takes effect at that edge. An accepted commit pulls `ready_o` low in the cycle right after the request. Slot k of the page is written at the (k+1)th edge after the request. `ready_o` returns high after PROG_CYCLES edges. The bench drives inputs on falling edges and samples on falling edges. It counts the falling edges at which `ready_o` is low and requires exactly PROG_CYCLES of them. It reads array contents only after `ready_o` has returned high. For refused requests, it checks `ready_o` on the falling edges that follow.

// File: rtl/pwb_pkg.sv
package pwb_pkg;
  typedef logic [7:0] byte_t;
  typedef enum logic {CM_IDLE, CM_PROG} cm_state_e;
endpackage

// File: rtl/pwb_loader.sv
module pwb_loader
  import pwb_pkg::*;
#(
  parameter int AW = 11,
  parameter int PAGE_BYTES = 32,
  localparam int PBW = $clog2(PAGE_BYTES),
  localparam int PGW = AW - PBW
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  start_i,
  input  logic [AW-1:0]         start_addr_i,
  input  logic                  fire_i,
  input  logic                  bit_i,
  input  logic                  end_i,
  input  logic                  clear_i,
  input  logic [PBW-1:0]        rd_idx_i,
  output byte_t                 rd_byte_o,
  output logic [PGW-1:0]        base_o,
  output logic [PAGE_BYTES-1:0] mask_o,
  output logic                  loading_o,
  output logic                  aligned_o
);
  logic [PBW-1:0] ptr;
  logic [2:0]     bcnt;
  logic [6:0]     sh;
  byte_t          pbuf [PAGE_BYTES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      loading_o <= 1'b0;
      base_o    <= '0;
      ptr       <= '0;
      bcnt      <= '0;
      sh        <= '0;
      mask_o    <= '0;
    end else if (clear_i) begin
      loading_o <= 1'b0;
      bcnt      <= '0;
      mask_o    <= '0;
    end else if (start_i) begin
      loading_o <= 1'b1;
      base_o    <= start_addr_i[AW-1:PBW];
      ptr       <= start_addr_i[PBW-1:0];
      bcnt      <= '0;
      mask_o    <= '0;
    end else begin
      if (end_i) loading_o <= 1'b0;
      if (fire_i) begin
        sh   <= {sh[5:0], bit_i};
        bcnt <= bcnt + 3'd1;
        if (bcnt == 3'd7) begin
          mask_o[ptr] <= 1'b1;
          ptr         <= ptr + 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (fire_i && bcnt == 3'd7 && !clear_i && !start_i) pbuf[ptr] <= {sh, bit_i};
  end

  assign rd_byte_o = pbuf[rd_idx_i];
  assign aligned_o = (bcnt == 3'd0);

  // R1
  slot_mark_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fire_i && bcnt == 3'd7 && !clear_i && !start_i) |=> mask_o[$past(ptr)]);
endmodule

// File: rtl/pwb_commit.sv
module pwb_commit
  import pwb_pkg::*;
#(
  parameter int PAGE_BYTES = 32,
  parameter int PROG_CYCLES = 64,
  localparam int PBW = $clog2(PAGE_BYTES),
  localparam int CW = $clog2(PROG_CYCLES + 1)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  go_i,
  input  logic [PAGE_BYTES-1:0] mask_i,
  output logic                  busy_o,
  output logic                  done_o,
  output logic [PBW-1:0]        idx_o,
  output logic                  we_req_o
);
  cm_state_e     st;
  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st  <= CM_IDLE;
      cnt <= '0;
    end else if (st == CM_IDLE) begin
      if (go_i) begin
        st  <= CM_PROG;
        cnt <= '0;
      end
    end else if (done_o) begin
      st <= CM_IDLE;
    end else begin
      cnt <= cnt + 1'b1;
    end
  end

  assign busy_o   = (st == CM_PROG);
  assign done_o   = busy_o && (32'(cnt) == PROG_CYCLES - 1);
  assign idx_o    = cnt[PBW-1:0];
  assign we_req_o = busy_o && (32'(cnt) < PAGE_BYTES) && mask_i[idx_o];

  // R3
  prog_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy_o |-> (32'(cnt) < PROG_CYCLES));
endmodule

// File: rtl/pwb_array.sv
module pwb_array
  import pwb_pkg::*;
#(
  parameter int AW = 11,
  localparam int DEPTH = 1 << AW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we_i,
  input  logic [AW-1:0] waddr_i,
  input  byte_t         wdata_i,
  input  logic [AW-1:0] raddr_i,
  output byte_t         rdata_o
);
  byte_t mem [DEPTH];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else if (we_i) begin
      mem[waddr_i] <= wdata_i;
    end
  end

  assign rdata_o = mem[raddr_i];
endmodule

// File: rtl/pwb_top.sv
module pwb_top
  import pwb_pkg::*;
#(
  parameter int AW = 11,
  parameter int PAGE_BYTES = 32,
  parameter int PROG_CYCLES = 64,
  localparam int PBW = $clog2(PAGE_BYTES),
  localparam int PGW = AW - PBW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          arm_i,
  input  logic          start_i,
  input  logic [AW-1:0] start_addr_i,
  input  logic          bit_valid_i,
  input  logic          bit_data_i,
  output logic          bit_ready_o,
  input  logic          load_end_i,
  input  logic          abort_i,
  input  logic          commit_i,
  output logic [AW-1:0] prot_addr_o,
  input  logic          prot_ok_i,
  output logic          mem_we_o,
  output logic [AW-1:0] mem_addr_o,
  output logic [7:0]    mem_data_o,
  input  logic [AW-1:0] rd_addr_i,
  output logic [7:0]    rd_data_o,
  output logic          ready_o
);
  logic                  wel, busy, done, loading, aligned, we_req;
  logic                  commit_ok, go, reject, clear;
  logic [PGW-1:0]        base;
  logic [PAGE_BYTES-1:0] mask;
  logic [PBW-1:0]        idx;
  byte_t                 cur_byte;

  assign commit_ok   = wel && !loading && aligned && (|mask);
  assign go          = commit_i && !busy && commit_ok;
  assign reject      = commit_i && !busy && !commit_ok;
  assign clear       = (abort_i && !busy) || reject || done;
  assign bit_ready_o = loading && !busy;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                       wel <= 1'b0;
    else if (done || reject)          wel <= 1'b0;
    else if (arm_i && !busy && !go)   wel <= 1'b1;
  end

  pwb_loader #(.AW(AW), .PAGE_BYTES(PAGE_BYTES)) u_load (
    .clk(clk), .rst_n(rst_n),
    .start_i(start_i && !busy), .start_addr_i(start_addr_i),
    .fire_i(bit_valid_i && bit_ready_o), .bit_i(bit_data_i),
    .end_i(load_end_i && !busy), .clear_i(clear),
    .rd_idx_i(idx), .rd_byte_o(cur_byte),
    .base_o(base), .mask_o(mask), .loading_o(loading), .aligned_o(aligned));

  pwb_commit #(.PAGE_BYTES(PAGE_BYTES), .PROG_CYCLES(PROG_CYCLES)) u_cm (
    .clk(clk), .rst_n(rst_n), .go_i(go), .mask_i(mask),
    .busy_o(busy), .done_o(done), .idx_o(idx), .we_req_o(we_req));

  assign prot_addr_o = {base, idx};
  assign mem_addr_o  = prot_addr_o;
  assign mem_data_o  = cur_byte;
  assign mem_we_o    = we_req && prot_ok_i;
  assign ready_o     = !busy;

  pwb_array #(.AW(AW)) u_arr (
    .clk(clk), .rst_n(rst_n), .we_i(mem_we_o), .waddr_i(mem_addr_o),
    .wdata_i(mem_data_o), .raddr_i(rd_addr_i), .rdata_o(rd_data_o));

  // R3
  busy_from_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(commit_i));
  // R8
  wel_cleared_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> !wel);
  // R6
  partial_refused_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (commit_i && !busy && !aligned) |=> !busy);
  // R9
  base_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> $stable(base));
endmodule

// File: tb/tb_pwb_top.sv
module tb_pwb_top;
  localparam int AW = 11;
  localparam int PROG = 64;

  logic clk = 0, rst_n = 0;
  logic arm = 0, start = 0, bvalid = 0, bdata = 0, lend = 0, abrt = 0, commit = 0;
  logic [AW-1:0] saddr = '0, raddr = '0, paddr, maddr;
  logic bready, mwe, ready;
  logic [7:0] mdata, rdata;
  logic block_en = 0;
  logic [AW-1:0] block_addr = '0;
  logic pok;
  int checks = 0, fails = 0;

  always #2 clk = ~clk;
  assign pok = !(block_en && paddr == block_addr);

  pwb_top #(.AW(AW), .PAGE_BYTES(32), .PROG_CYCLES(PROG)) dut (
    .clk(clk), .rst_n(rst_n), .arm_i(arm), .start_i(start), .start_addr_i(saddr),
    .bit_valid_i(bvalid), .bit_data_i(bdata), .bit_ready_o(bready),
    .load_end_i(lend), .abort_i(abrt), .commit_i(commit),
    .prot_addr_o(paddr), .prot_ok_i(pok), .mem_we_o(mwe), .mem_addr_o(maddr),
    .mem_data_o(mdata), .rd_addr_i(raddr), .rd_data_o(rdata), .ready_o(ready));

  task automatic chk(input logic ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic pulse(ref logic s);
    @(negedge clk); s = 1;
    @(negedge clk); s = 0;
  endtask

  task automatic open_load(input logic [AW-1:0] a);
    @(negedge clk); saddr = a; start = 1;
    @(negedge clk); start = 0;
  endtask

  task automatic send_bits(input logic [7:0] v, input int n);
    for (int i = 7; i > 7 - n; i--) begin
      @(negedge clk); bvalid = 1; bdata = v[i];
    end
    @(negedge clk); bvalid = 0;
  endtask

  task automatic rd(input logic [AW-1:0] a, output logic [7:0] v);
    raddr = a; #1; v = rdata;
  endtask

  // returns number of falling edges with ready low after a commit request
  task automatic do_commit(output int low);
    low = 0;
    @(negedge clk); commit = 1;
    @(negedge clk); commit = 0;
    while (!ready && low < 10 * PROG) begin low++; @(negedge clk); end
  endtask

  task automatic t_reset;
    logic [7:0] v;
    chk(ready == 1, "R3 reset ready", ready, 1);
    chk(bready == 0, "R11 reset bit_ready", bready, 0);
    rd(11'h045, v); chk(v == 0, "R4 reset array", v, 0);
  endtask

  task automatic t_basic;
    int low; logic [7:0] v;
    pulse(arm);
    open_load(11'h045);
    chk(bready == 1, "R11 ready after start", bready, 1);
    send_bits(8'hA5, 8); send_bits(8'h3C, 8); send_bits(8'h7E, 8);
    pulse(lend);
    chk(bready == 0, "R11 ready after end", bready, 0);
    // during busy: try new start, arm and bits
    @(negedge clk); commit = 1;
    @(negedge clk); commit = 0;
    chk(ready == 0, "R3 busy next cycle", ready, 0);
    low = 1;
    saddr = 11'h300; start = 1; arm = 1; bvalid = 1;
    @(negedge clk); start = 0; arm = 0; bvalid = 0;
    chk(bready == 0, "R9 bit_ready while busy", bready, 0);
    while (!ready && low < 10 * PROG) begin low++; @(negedge clk); end
    chk(low == PROG, "R3 busy length", low, PROG);
    rd(11'h045, v); chk(v == 8'hA5, "R1 byte0", v, 8'hA5);
    rd(11'h046, v); chk(v == 8'h3C, "R1 byte1", v, 8'h3C);
    rd(11'h047, v); chk(v == 8'h7E, "R1 byte2", v, 8'h7E);
    rd(11'h044, v); chk(v == 0, "R4 below untouched", v, 0);
    rd(11'h048, v); chk(v == 0, "R4 above untouched", v, 0);
    rd(11'h300, v); chk(v == 0, "R9 start ignored", v, 0);
    chk(bready == 0, "R9 no load opened while busy", bready, 0);
    // latch cleared after completion; arm during busy ignored
    open_load(11'h050); send_bits(8'h11, 8); pulse(lend);
    do_commit(low);
    chk(low == 0, "R8 second commit refused", low, 0);
  endtask

  task automatic t_wrap;
    int low; logic [7:0] v;
    pulse(arm);
    open_load(11'h1FE);
    for (int b = 0; b < 34; b++) send_bits(8'(b + 1), 8);
    pulse(lend);
    do_commit(low);
    chk(low == PROG, "R2 commit runs", low, PROG);
    rd(11'h1FE, v); chk(v == 8'd33, "R2 slot30 overwritten", v, 33);
    rd(11'h1FF, v); chk(v == 8'd34, "R2 slot31 overwritten", v, 34);
    rd(11'h1E0, v); chk(v == 8'd3, "R2 slot0", v, 3);
    rd(11'h1FD, v); chk(v == 8'd32, "R2 slot29", v, 32);
    rd(11'h200, v); chk(v == 0, "R2 next page untouched", v, 0);
  endtask

  task automatic t_partial;
    int low;
    pulse(arm);
    open_load(11'h080); send_bits(8'hFF, 8); send_bits(8'hFF, 3); pulse(lend);
    do_commit(low);
    chk(low == 0, "R6 partial refused", low, 0);
    open_load(11'h080); send_bits(8'h55, 8); pulse(lend);
    do_commit(low);
    chk(low == 0, "R6 latch cleared by refusal", low, 0);
  endtask

  task automatic t_no_end;
    int low; logic [7:0] v;
    pulse(arm);
    open_load(11'h0C0); send_bits(8'h99, 8);
    do_commit(low);
    chk(low == 0, "R7 commit while loading refused", low, 0);
    chk(bready == 0, "R11 load closed by refusal", bready, 0);
    rd(11'h0C0, v); chk(v == 0, "R7 nothing written", v, 0);
  endtask

  task automatic t_protect;
    int low; logic [7:0] v;
    block_en = 1; block_addr = 11'h101;
    pulse(arm);
    open_load(11'h100);
    send_bits(8'h10, 8); send_bits(8'h20, 8); send_bits(8'h30, 8); send_bits(8'h40, 8);
    pulse(lend);
    do_commit(low);
    block_en = 0;
    chk(low == PROG, "R5 commit runs", low, PROG);
    rd(11'h101, v); chk(v == 0, "R5 protected dropped", v, 0);
    rd(11'h100, v); chk(v == 8'h10, "R5 neighbour written", v, 8'h10);
    rd(11'h103, v); chk(v == 8'h40, "R5 last written", v, 8'h40);
  endtask

  task automatic t_abort;
    int low;
    pulse(arm);
    open_load(11'h140); send_bits(8'h77, 8);
    pulse(abrt);
    chk(bready == 0, "R10 abort closes load", bready, 0);
    pulse(lend);
    do_commit(low);
    chk(low == 0, "R10 commit after abort refused", low, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_basic();
    t_wrap();
    t_partial();
    t_no_end();
    t_protect();
    t_abort();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule